// File: doc/BRIEF.md
# Load/Store Ordering Release Walker

This block decides, once per clock, which memory instructions in an age-ordered chain may drop their ordering dependency and compete for issue. The chain is presented as a fixed array of slots, where slot 0 is the oldest entry and higher slots are younger. Each slot has a set of flags: valid, address known, store, speculative, and an issue-available answer from the scheduler. The block walks the slots from oldest to youngest and releases a contiguous run that starts at the head. The registered result is a dependency-clear mask.

The release rule is chosen at elaboration. In two-phase mode the address is resolved before the access. An entry is released only when its address is known and the scheduler says it can issue, and the first entry that fails either test ends the walk. In one-phase mode stores act as barriers. A speculative store at the head blocks everything. A store at the head goes out alone. A load at the head lets the loads behind it go out, up to the first store. A flush input empties the mask on the following cycle.

Top module: `ldst_order_walker`

## Requirements
- R1: While reset is asserted, and on the cycle after a clock edge at which `flush` is 1, `dep_clear` is all zeros. Flush takes priority over every slot input.
- R2: `dep_clear` is registered. The value seen after a rising edge is computed from the inputs sampled at that edge, and inputs do not reach the output combinationally.
- R3: Bit i of every slot bus and of `dep_clear` belongs to slot i, and slot 0 is the oldest. `dep_clear` is always a contiguous run of ones that starts at bit 0, which may be empty.
- R4: Two-phase mode: a slot whose `slot_addr_ok` bit is 0 is not released, and no younger slot is released.
- R5: Two-phase mode: a slot whose `slot_issue_ok` bit is 0 is not released, and no younger slot is released.
- R6: Both modes: a slot whose `slot_valid` bit is 0 ends the chain. That slot and every younger slot are not released.
- R7: One-phase mode: if slot 0 is valid with both its store bit and its speculative bit at 1, the mask is all zeros.
- R8: One-phase mode: if slot 0 is a valid non-speculative store, only bit 0 is set.
- R9: One-phase mode: if slot 0 is a valid load (store bit 0), slot 0 and the loads that follow it are released, up to the first store or invalid slot. That slot is excluded. The address, issue and speculative flags of loads have no effect.
- R10: Two-phase mode: the store and speculative flags have no effect on the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Clears the mask at the next edge |
| slot_valid | input | DEPTH | Slot holds a chain entry |
| slot_addr_ok | input | DEPTH | Address of the slot is resolved |
| slot_is_store | input | DEPTH | Slot is a store (0 = load) |
| slot_is_spec | input | DEPTH | Slot is still speculative |
| slot_issue_ok | input | DEPTH | Scheduler would issue the slot if released |
| dep_clear | output | DEPTH | Registered dependency-clear mask, bit i = slot i |

## Verification
The hardest case to reach is a walk cut short deep in the chain. All older slots must pass, and exactly one younger slot must fail on a single flag, with the younger slots behind it still passing, so that a walk that does not stop would show up. The directed stimulus builds fully valid chains with a single hole placed mid-chain in the address, issue, valid or store flag. One-phase and two-phase instances see identical inputs, which shows that each mode ignores the flags the other mode uses. A pseudo-random run of mostly valid chains then covers the mixed cases.

// File: rtl/ldst_walk_pkg.sv
package ldst_walk_pkg;
   localparam int MAX_DEPTH = 64;

   typedef enum logic {
      WALK_TWO_PHASE = 1'b0,
      WALK_ONE_PHASE = 1'b1
   } walk_mode_e;
endpackage

// File: rtl/ldst_walk_cell_addr.sv
// Two-phase slot: passes the walk on only if the address is known and issue is granted.
module ldst_walk_cell_addr (
   input  logic go_in,
   input  logic valid,
   input  logic addr_ok,
   input  logic issue_ok,
   output logic release_o
);
   always_comb begin
      release_o = go_in & valid & addr_ok & issue_ok;
   end
endmodule

// File: rtl/ldst_walk_cell_load.sv
// One-phase follower slot: only a valid load behind a released load goes out.
module ldst_walk_cell_load (
   input  logic go_in,
   input  logic valid,
   input  logic is_store,
   output logic release_o
);
   always_comb begin
      release_o = go_in & valid & ~is_store;
   end
endmodule

// File: rtl/ldst_walk_mask_reg.sv
module ldst_walk_mask_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (flush)
         q <= '0;
      else
         q <= d;
   end
endmodule

// File: rtl/ldst_order_walker.sv
module ldst_order_walker
   import ldst_walk_pkg::*;
#(
   parameter int         DEPTH = 8,
   parameter walk_mode_e MODE  = WALK_TWO_PHASE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [DEPTH-1:0] slot_valid,
   input  logic [DEPTH-1:0] slot_addr_ok,
   input  logic [DEPTH-1:0] slot_is_store,
   input  logic [DEPTH-1:0] slot_is_spec,
   input  logic [DEPTH-1:0] slot_issue_ok,
   output logic [DEPTH-1:0] dep_clear
);
   localparam int LAST = DEPTH - 1;

   if (DEPTH < 2 || DEPTH > MAX_DEPTH) begin : g_bad_depth
      $error("ldst_order_walker: DEPTH out of range");
   end

   logic [DEPTH-1:0] walk_mask;

   if (MODE == WALK_TWO_PHASE) begin : g_two
      logic [DEPTH-1:0] go;
      logic             unused_two;

      assign unused_two = ^{slot_is_store, slot_is_spec};

      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         if (i == 0) begin : g_head
            assign go[i] = 1'b1;
         end else begin : g_tail
            assign go[i] = walk_mask[i-1];
         end
         ldst_walk_cell_addr u_cell (
            .go_in    (go[i]),
            .valid    (slot_valid[i]),
            .addr_ok  (slot_addr_ok[i]),
            .issue_ok (slot_issue_ok[i]),
            .release_o(walk_mask[i])
         );
      end
   end else begin : g_one
      logic [DEPTH-1:1] go;
      logic             head_pass;
      logic             unused_one;

      assign unused_one = ^{slot_addr_ok, slot_issue_ok, slot_is_spec[LAST:1]};

      // Head: a speculative store blocks everything; any other head goes out.
      assign walk_mask[0] = slot_valid[0] & ~(slot_is_store[0] & slot_is_spec[0]);
      // Only a released load lets younger entries follow.
      assign head_pass    = walk_mask[0] & ~slot_is_store[0];

      for (genvar i = 1; i < DEPTH; i++) begin : g_slot
         if (i == 1) begin : g_first
            assign go[i] = head_pass;
         end else begin : g_rest
            assign go[i] = walk_mask[i-1];
         end
         ldst_walk_cell_load u_cell (
            .go_in    (go[i]),
            .valid    (slot_valid[i]),
            .is_store (slot_is_store[i]),
            .release_o(walk_mask[i])
         );
      end
   end

   ldst_walk_mask_reg #(.WIDTH(DEPTH)) u_mask (
      .clk  (clk),
      .rst_n(rst_n),
      .flush(flush),
      .d    (walk_mask),
      .q    (dep_clear)
   );
endmodule

// File: rtl/ldst_order_walker_chk.sv
module ldst_order_walker_chk
   import ldst_walk_pkg::*;
#(
   parameter int         DEPTH = 8,
   parameter walk_mode_e MODE  = WALK_TWO_PHASE
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic [DEPTH-1:0] slot_valid,
   input logic [DEPTH-1:0] slot_addr_ok,
   input logic [DEPTH-1:0] slot_is_store,
   input logic [DEPTH-1:0] slot_is_spec,
   input logic [DEPTH-1:0] slot_issue_ok,
   input logic [DEPTH-1:0] dep_clear
);
   logic unused_chk;
   assign unused_chk = ^{slot_addr_ok, slot_issue_ok, slot_is_store, slot_is_spec};

   assert_flush_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (dep_clear == '0));

   assert_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((dep_clear & (dep_clear + DEPTH'(1))) == '0));

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assert_invalid_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !slot_valid[i] |=> !dep_clear[i]);

      if (MODE == WALK_TWO_PHASE) begin : g_two
         assert_addr_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_addr_ok[i] |=> !dep_clear[i]);
         assert_issue_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_issue_ok[i] |=> !dep_clear[i]);
      end else if (i > 0) begin : g_one
         assert_store_barrier_R9: assert property (@(posedge clk) disable iff (!rst_n)
            slot_is_store[i] |=> !dep_clear[i]);
      end
   end

   if (MODE == WALK_ONE_PHASE) begin : g_head
      assert_spec_store_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (slot_valid[0] && slot_is_store[0] && slot_is_spec[0]) |=> (dep_clear == '0));
      assert_store_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!flush && slot_valid[0] && slot_is_store[0] && !slot_is_spec[0])
         |=> (dep_clear == DEPTH'(1)));
   end
endmodule

bind ldst_order_walker ldst_order_walker_chk #(.DEPTH(DEPTH), .MODE(MODE)) u_chk (.*);

// File: tb/sim_ldst_order_walker.sv
module sim_ldst_order_walker;
   import ldst_walk_pkg::*;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         flush = 1'b0;
   logic [N-1:0] v = '0, a = '0, s = '0, sp = '0, iss = '0;
   logic [N-1:0] dep2, dep1;

   int checks = 0;
   int fails  = 0;

   logic [N-1:0] q_two[$];
   logic [N-1:0] q_one[$];
   string        q_tag[$];

   always #2 clk = ~clk;

   ldst_order_walker #(.DEPTH(N), .MODE(WALK_TWO_PHASE)) u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .slot_valid(v), .slot_addr_ok(a),
      .slot_is_store(s), .slot_is_spec(sp), .slot_issue_ok(iss), .dep_clear(dep2));

   ldst_order_walker #(.DEPTH(N), .MODE(WALK_ONE_PHASE)) u1 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .slot_valid(v), .slot_addr_ok(a),
      .slot_is_store(s), .slot_is_spec(sp), .slot_issue_ok(iss), .dep_clear(dep1));

   function automatic logic [N-1:0] model_two(logic [N-1:0] vv, logic [N-1:0] aa,
                                              logic [N-1:0] ii);
      logic [N-1:0] m = '0;
      for (int k = 0; k < N; k++) begin
         if (!vv[k] || !aa[k] || !ii[k]) break;
         m[k] = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [N-1:0] model_one(logic [N-1:0] vv, logic [N-1:0] ss,
                                              logic [N-1:0] pp);
      logic [N-1:0] m = '0;
      if (!vv[0]) return m;
      if (ss[0] && pp[0]) return m;
      m[0] = 1'b1;
      if (ss[0]) return m;
      for (int k = 1; k < N; k++) begin
         if (!vv[k] || ss[k]) break;
         m[k] = 1'b1;
      end
      return m;
   endfunction

   function automatic void check(string tag, string who, logic [N-1:0] got, logic [N-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", tag, who, got, exp);
      end
   endfunction

   // Driver: apply one input set and queue the expected result.
   task automatic drive(input logic [N-1:0] vv, aa, ss, pp, ii, input logic fl, input string tag);
      @(negedge clk);
      v = vv; a = aa; s = ss; sp = pp; iss = ii; flush = fl;
      q_two.push_back(fl ? '0 : model_two(vv, aa, ii));
      q_one.push_back(fl ? '0 : model_one(vv, ss, pp));
      q_tag.push_back(tag);
   endtask

   // Monitor: one registered result per driven cycle (R2).
   always @(posedge clk) begin
      #1;
      if (q_tag.size() > 0) begin
         string t;
         t = q_tag.pop_front();
         check(t, "two-phase", dep2, q_two.pop_front());
         check(t, "one-phase", dep1, q_one.pop_front());
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      v = 8'hFF; a = 8'hFF; iss = 8'hFF;
      repeat (3) @(posedge clk);
      #1;
      check("R1", "two-phase reset", dep2, '0);
      check("R1", "one-phase reset", dep1, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2/R3: full chain of loads, everything ready.
      drive(8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0, "R3");
      // R4: address hole at slot 3, younger slots ready.
      drive(8'hFF, 8'hF7, 8'h00, 8'h00, 8'hFF, 1'b0, "R4");
      // R4: address missing at the head.
      drive(8'hFF, 8'hFE, 8'h00, 8'h00, 8'hFF, 1'b0, "R4");
      // R5: issue refused at slot 5.
      drive(8'hFF, 8'hFF, 8'h00, 8'h00, 8'hDF, 1'b0, "R5");
      // R6: chain of three entries.
      drive(8'h07, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0, "R6");
      // R6: hole in valid at slot 2 with valid entries behind it.
      drive(8'hFB, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0, "R6");
      // R7 / R10: speculative store at head.
      drive(8'hFF, 8'hFF, 8'h01, 8'h01, 8'hFF, 1'b0, "R7");
      // R8 / R10: non-speculative store at head.
      drive(8'hFF, 8'hFF, 8'h01, 8'h00, 8'hFF, 1'b0, "R8");
      // R9: load head, store at slot 4, loads speculative and not ready.
      drive(8'hFF, 8'h00, 8'h10, 8'hEE, 8'h00, 1'b0, "R9");
      // R9: store barrier at slot 1.
      drive(8'hFF, 8'hFF, 8'h02, 8'h00, 8'hFF, 1'b0, "R9");
      // R10: store and speculative flags mid-chain do not cut the two-phase walk.
      drive(8'hFF, 8'hFF, 8'h24, 8'hFF, 8'h7F, 1'b0, "R10");
      // R1: flush overrides a fully ready chain.
      drive(8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b1, "R1");
      // R2: recovery right after flush.
      drive(8'h3F, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0, "R2");
      // Head invalid.
      drive(8'hFE, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0, "R6");

      lfsr = 32'hACE1_1234;
      for (int n = 0; n < 60; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         drive(lfsr[7:0] | lfsr[15:8], lfsr[15:8] | lfsr[23:16] | lfsr[7:0],
               lfsr[23:16] & lfsr[31:24], lfsr[31:24], lfsr[19:12] | lfsr[27:20],
               (n % 17) == 16, "R3");
      end

      @(negedge clk);
      flush = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule